// File: doc/BRIEF.md
# AES-128 Reversible Round-Key Walker

This block supplies AES-128 round keys to a cipher datapath one round at a time, without ever holding the expanded schedule. It keeps three 128-bit registers: the loaded user key, the round key currently offered, and a cached copy of the final round key. It derives each following key from the current one in a single clock cycle. For encryption it walks the schedule from the user key up to round ten. For decryption it starts from the cached final key and inverts the schedule step by step back to the user key.

The final key becomes available in one of two ways. A full encryption pass caches it as a by-product. A dedicated generate command walks the schedule forward in ten cycles without presenting any keys. A decryption request made before the cache is valid is refused with an error flag. The datapath drives `start` with a direction and then pulses `advance` once per round. It reads `rkey` whenever `rkey_valid` is high.

Top module: `aes_rkey_walker`

## Requirements
- R1: After synchronous reset, `rkey_valid`, `dec_ready`, `dec_err` and `gen_busy` are 0 and `round_idx` is 0.
- R2: A `start` with `dir_dec`=0 accepted while idle makes `rkey_valid` 1 on the next cycle, with `round_idx`=0 and `rkey` equal to the loaded key (word 0 in bits 127:96).
- R3: In an encryption pass, each `advance` moves `round_idx` up by one and replaces `rkey` with the next AES-128 expansion round key. The round constants used rise through 01,02,04,08,10,20,40,80,1B,36.
- R4: An `advance` while `round_idx` is 10 ends the pass, and `rkey_valid` is 0 on the next cycle.
- R5: A `dkgen` accepted while idle holds `gen_busy` high for exactly 10 cycles with `rkey_valid` low. `dec_ready` is 1 when `gen_busy` falls.
- R6: An encryption pass that advances to `round_idx`=10 sets `dec_ready`.
- R7: A `start` with `dir_dec`=1 while `dec_ready` is 1 presents the round-10 key with `round_idx`=0. Each `advance` presents the previous schedule key, with round constants falling, so that processing round r carries schedule key 10-r.
- R8: A `start` with `dir_dec`=1 while `dec_ready` is 0 sets `dec_err` on the next cycle and presents no key. `dec_err` stays set until the next accepted `start` or `key_load`.
- R9: `key_load` while idle stores `key_in` and clears `dec_ready` and `dec_err`. In the same cycle it wins over `dkgen`, which wins over `start`; the losing commands are ignored.
- R10: `start`, `dkgen` and `key_load` are ignored while a pass or a generation is running, and the stored user key and cached final key are left unchanged.
- R11: While `rkey_valid` is 1 and `advance` is 0, `rkey` and `round_idx` hold. `advance` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Store `key_in` as the user key (idle only) |
| key_in | input | 128 | User key, word 0 in bits 127:96 |
| dir_dec | input | 1 | Direction for `start`: 0 encrypt, 1 decrypt |
| start | input | 1 | Begin a pass in the chosen direction |
| advance | input | 1 | Step to the next round key |
| dkgen | input | 1 | Precompute and cache the final round key |
| rkey | output | 128 | Current round key |
| rkey_valid | output | 1 | A pass is running and `rkey` is usable |
| round_idx | output | 4 | Processing round of `rkey` (0 to 10) |
| dec_ready | output | 1 | Final round key is cached |
| dec_err | output | 1 | Decryption was requested without a cached key |
| gen_busy | output | 1 | Key generation in progress |

## Verification
The bench builds the block with its default `ROUNDS` of 10, which is the AES-128 configuration. At that value every one of the eleven schedule keys and all ten round constants are reachable in both walk directions. The standard example key is compared against published round keys. A sweep of further keys is compared against an expansion model in the bench, whose S-box is found by brute-force field inversion. Both routes to a cached final key are used (generation and a full encryption pass), and commands are sent mid-pass and mid-generation to confirm they are ignored.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

    localparam int NR_128  = 10;
    localparam int WORD_W  = 32;
    localparam int NK      = 4;
    localparam int KEY_W   = WORD_W * NK;
    localparam int BYTE_W  = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [KEY_W-1:0]  key_t;

    // w0 is the first schedule word and occupies the top bits
    typedef struct packed {
        word_t w0;
        word_t w1;
        word_t w2;
        word_t w3;
    } rkey_s;

    typedef enum logic [1:0] {KS_IDLE, KS_GEN, KS_RUN} ks_state_e;
    typedef enum logic       {WALK_FWD, WALK_BWD}      walk_e;
    typedef enum logic [1:0] {SEL_HOLD, SEL_BASE, SEL_TAIL, SEL_STEP} cur_sel_e;

    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_xtime(p);
        end
        return acc;
    endfunction

    // a^254 is the field inverse (and maps 0 to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] r;
        sq = a;
        r  = 8'h01;
        for (int i = 0; i < 7; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    function automatic logic [7:0] sbox_byte(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [7:0] rcon_byte(input logic [3:0] idx);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 0; i < 15; i++) begin
            if (4'(i) < idx) r = gf_xtime(r);
        end
        return r;
    endfunction

endpackage

// File: rtl/ks_subword.sv
module ks_subword
    import aes_ks_pkg::*;
#(
    parameter int LANES = NK
) (
    input  logic [LANES*BYTE_W-1:0] din,
    output logic [LANES*BYTE_W-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*BYTE_W +: BYTE_W] = sbox_byte(din[g*BYTE_W +: BYTE_W]);
    end
endmodule

// File: rtl/ks_step.sv
module ks_step
    import aes_ks_pkg::*;
(
    input  rkey_s      cur,
    input  walk_e      walk,
    input  logic [3:0] rc_idx,
    output rkey_s      nxt
);
    word_t back3;
    word_t sw_in;
    word_t rot;
    word_t sub;
    word_t fmix;

    // Backward walk: the previous key's last word is cur.w3 ^ cur.w2
    assign back3 = cur.w3 ^ cur.w2;
    assign sw_in = (walk == WALK_BWD) ? back3 : cur.w3;
    assign rot   = {sw_in[23:0], sw_in[31:24]};

    ks_subword #(.LANES(NK)) u_sub (
        .din  (rot),
        .dout (sub)
    );

    assign fmix = sub ^ {rcon_byte(rc_idx), 24'h000000};

    always_comb begin
        if (walk == WALK_FWD) begin
            nxt.w0 = cur.w0 ^ fmix;
            nxt.w1 = cur.w1 ^ nxt.w0;
            nxt.w2 = cur.w2 ^ nxt.w1;
            nxt.w3 = cur.w3 ^ nxt.w2;
        end else begin
            nxt.w3 = back3;
            nxt.w2 = cur.w2 ^ cur.w1;
            nxt.w1 = cur.w1 ^ cur.w0;
            nxt.w0 = cur.w0 ^ fmix;
        end
    end
endmodule

// File: rtl/ks_keyregs.sv
module ks_keyregs
    import aes_ks_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  key_t     key_in,
    input  logic     base_we,
    input  logic     tail_we,
    input  cur_sel_e cur_sel,
    input  rkey_s    step_key,
    output rkey_s    cur_key
);
    rkey_s base_q;
    rkey_s tail_q;
    rkey_s cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            tail_q <= '0;
            cur_q  <= '0;
        end else begin
            if (base_we) base_q <= rkey_s'(key_in);
            if (tail_we) tail_q <= step_key;
            case (cur_sel)
                SEL_BASE: cur_q <= base_q;
                SEL_TAIL: cur_q <= tail_q;
                SEL_STEP: cur_q <= step_key;
                default:  cur_q <= cur_q;
            endcase
        end
    end

    assign cur_key = cur_q;
endmodule

// File: rtl/ks_ctrl.sv
module ks_ctrl
    import aes_ks_pkg::*;
#(
    parameter int ROUNDS = NR_128,
    localparam int CNT_W = $clog2(ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_load,
    input  logic             start,
    input  logic             dir_dec,
    input  logic             advance,
    input  logic             dkgen,
    output cur_sel_e         cur_sel,
    output logic             base_we,
    output logic             tail_we,
    output walk_e            walk,
    output logic [3:0]       rc_idx,
    output logic             rkey_valid,
    output logic [CNT_W-1:0] round_idx,
    output logic             dec_ready,
    output logic             dec_err,
    output logic             gen_busy
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS);

    ks_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    walk_e            walk_q;
    logic             ready_q;
    logic             err_q;

    logic idle, acc_load, acc_gen, acc_start, acc_enc, acc_dec, bad_dec;
    logic run_step, gen_step, gen_last, enc_last;

    assign idle      = (state_q == KS_IDLE);
    assign acc_load  = idle & key_load;
    assign acc_gen   = idle & ~key_load & dkgen;
    assign acc_start = idle & ~key_load & ~dkgen & start;
    assign acc_enc   = acc_start & ~dir_dec;
    assign acc_dec   = acc_start & dir_dec & ready_q;
    assign bad_dec   = acc_start & dir_dec & ~ready_q;

    assign gen_step  = (state_q == KS_GEN);
    assign run_step  = (state_q == KS_RUN) & advance & (cnt_q != LAST);
    assign gen_last  = gen_step & (cnt_q == LAST - 1'b1);
    assign enc_last  = run_step & (walk_q == WALK_FWD) & (cnt_q == LAST - 1'b1);

    always_comb begin
        if (acc_gen || acc_enc)          cur_sel = SEL_BASE;
        else if (acc_dec)                cur_sel = SEL_TAIL;
        else if (gen_step || run_step)   cur_sel = SEL_STEP;
        else                             cur_sel = SEL_HOLD;
    end

    assign base_we = acc_load;
    assign tail_we = gen_last | enc_last;
    assign walk    = walk_q;
    assign rc_idx  = (walk_q == WALK_BWD) ? 4'(LAST - 1'b1 - cnt_q) : 4'(cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_IDLE;
            cnt_q   <= '0;
            walk_q  <= WALK_FWD;
            ready_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                KS_IDLE: begin
                    if (acc_load) begin
                        ready_q <= 1'b0;
                        err_q   <= 1'b0;
                    end else if (acc_gen) begin
                        state_q <= KS_GEN;
                        cnt_q   <= '0;
                        walk_q  <= WALK_FWD;
                    end else if (acc_enc || acc_dec) begin
                        state_q <= KS_RUN;
                        cnt_q   <= '0;
                        walk_q  <= acc_dec ? WALK_BWD : WALK_FWD;
                        err_q   <= 1'b0;
                    end else if (bad_dec) begin
                        err_q   <= 1'b1;
                    end
                end
                KS_GEN: begin
                    if (gen_last) begin
                        state_q <= KS_IDLE;
                        cnt_q   <= '0;
                        ready_q <= 1'b1;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                KS_RUN: begin
                    if (advance) begin
                        if (cnt_q == LAST) begin
                            state_q <= KS_IDLE;
                            cnt_q   <= '0;
                            walk_q  <= WALK_FWD;
                        end else begin
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                    if (enc_last) ready_q <= 1'b1;
                end
                default: state_q <= KS_IDLE;
            endcase
        end
    end

    assign rkey_valid = (state_q == KS_RUN);
    assign round_idx  = (state_q == KS_RUN) ? cnt_q : '0;
    assign dec_ready  = ready_q;
    assign dec_err    = err_q;
    assign gen_busy   = gen_step;
endmodule

// File: rtl/aes_rkey_walker.sv
module aes_rkey_walker
    import aes_ks_pkg::*;
#(
    parameter int ROUNDS = NR_128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         key_load,
    input  logic [127:0]                 key_in,
    input  logic                         dir_dec,
    input  logic                         start,
    input  logic                         advance,
    input  logic                         dkgen,
    output logic [127:0]                 rkey,
    output logic                         rkey_valid,
    output logic [$clog2(ROUNDS+1)-1:0]  round_idx,
    output logic                         dec_ready,
    output logic                         dec_err,
    output logic                         gen_busy
);
    cur_sel_e   cur_sel;
    logic       base_we;
    logic       tail_we;
    walk_e      walk;
    logic [3:0] rc_idx;
    rkey_s      cur_key;
    rkey_s      step_key;

    ks_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .key_load   (key_load),
        .start      (start),
        .dir_dec    (dir_dec),
        .advance    (advance),
        .dkgen      (dkgen),
        .cur_sel    (cur_sel),
        .base_we    (base_we),
        .tail_we    (tail_we),
        .walk       (walk),
        .rc_idx     (rc_idx),
        .rkey_valid (rkey_valid),
        .round_idx  (round_idx),
        .dec_ready  (dec_ready),
        .dec_err    (dec_err),
        .gen_busy   (gen_busy)
    );

    ks_step u_step (
        .cur    (cur_key),
        .walk   (walk),
        .rc_idx (rc_idx),
        .nxt    (step_key)
    );

    ks_keyregs u_regs (
        .clk      (clk),
        .rst      (rst),
        .key_in   (key_in),
        .base_we  (base_we),
        .tail_we  (tail_we),
        .cur_sel  (cur_sel),
        .step_key (step_key),
        .cur_key  (cur_key)
    );

    assign rkey = cur_key;
endmodule

// File: rtl/aes_ks_chk.sv
module aes_ks_chk
    import aes_ks_pkg::*;
#(
    parameter int ROUNDS = NR_128
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         key_load,
    input logic                         dir_dec,
    input logic                         start,
    input logic                         advance,
    input logic                         dkgen,
    input logic [127:0]                 rkey,
    input logic                         rkey_valid,
    input logic [$clog2(ROUNDS+1)-1:0]  round_idx,
    input logic                         dec_ready,
    input logic                         dec_err,
    input logic                         gen_busy
);
    localparam int RW = $clog2(ROUNDS + 1);
    localparam logic [RW-1:0] LAST = RW'(ROUNDS);

    logic idle_in;
    logic [RW:0] busy_run;

    assign idle_in = !rkey_valid && !gen_busy;

    always_ff @(posedge clk) begin
        if (rst)           busy_run <= '0;
        else if (gen_busy) busy_run <= busy_run + 1'b1;
        else               busy_run <= '0;
    end

    a_r2_enc_start: assert property (@(posedge clk) disable iff (rst)
        (idle_in && start && !dir_dec && !key_load && !dkgen)
        |=> (rkey_valid && round_idx == '0));

    a_r3_idx_step: assert property (@(posedge clk) disable iff (rst)
        (rkey_valid && advance && round_idx != LAST)
        |=> (rkey_valid && round_idx == $past(round_idx) + 1'b1));

    a_r4_pass_end: assert property (@(posedge clk) disable iff (rst)
        (rkey_valid && advance && round_idx == LAST) |=> !rkey_valid);

    a_r5_gen_len: assert property (@(posedge clk) disable iff (rst)
        gen_busy |-> (busy_run < (RW+1)'(ROUNDS)));

    a_r5_gen_done: assert property (@(posedge clk) disable iff (rst)
        $fell(gen_busy) |-> (busy_run == (RW+1)'(ROUNDS) && dec_ready));

    a_r8_refuse: assert property (@(posedge clk) disable iff (rst)
        (idle_in && start && dir_dec && !dec_ready && !key_load && !dkgen)
        |=> (dec_err && !rkey_valid));

    a_r9_load_clears: assert property (@(posedge clk) disable iff (rst)
        (idle_in && key_load) |=> (!dec_ready && !dec_err && !rkey_valid));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (rkey_valid && !advance)
        |=> (rkey_valid && $stable(rkey) && $stable(round_idx)));
endmodule

bind aes_rkey_walker aes_ks_chk #(.ROUNDS(ROUNDS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .key_load   (key_load),
    .dir_dec    (dir_dec),
    .start      (start),
    .advance    (advance),
    .dkgen      (dkgen),
    .rkey       (rkey),
    .rkey_valid (rkey_valid),
    .round_idx  (round_idx),
    .dec_ready  (dec_ready),
    .dec_err    (dec_err),
    .gen_busy   (gen_busy)
);

// File: tb/sim_aes_rkey_walker.sv
module sim_aes_rkey_walker;
    logic         clk = 1'b0;
    logic         rst;
    logic         key_load, dir_dec, start, advance, dkgen;
    logic [127:0] key_in;
    logic [127:0] rkey;
    logic         rkey_valid, dec_ready, dec_err, gen_busy;
    logic [3:0]   round_idx;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0]   sb [256];
    logic [127:0] fips_rk [11];

    always #10 clk = ~clk;

    aes_rkey_walker u0 (
        .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in),
        .dir_dec(dir_dec), .start(start), .advance(advance), .dkgen(dkgen),
        .rkey(rkey), .rkey_valid(rkey_valid), .round_idx(round_idx),
        .dec_ready(dec_ready), .dec_err(dec_err), .gen_busy(gen_busy)
    );

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1b) : {x[6:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [127:0] model_rk(input logic [127:0] key, input int k);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127 - 32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
                rc = rc[7] ? ({rc[6:0], 1'b0} ^ 8'h1b) : {rc[6:0], 1'b0};
            end
            w[i] = w[i-4] ^ t;
        end
        return {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic load_key(input logic [127:0] k);
        key_in = k; key_load = 1'b1; tick; key_load = 1'b0;
    endtask

    task automatic run_gen;
        int n = 0;
        dkgen = 1'b1; tick; dkgen = 1'b0;
        while (gen_busy && n < 50) begin
            check(!rkey_valid, "R5 valid low during gen", 128'(rkey_valid), 0);
            n++;
            tick;
        end
        check(n == 10, "R5 gen cycle count", 128'(n), 10);
        check(dec_ready, "R5 ready after gen", 128'(dec_ready), 1);
    endtask

    // full pass; fips=1 compares with the published keys
    task automatic run_pass(input logic [127:0] key, input bit dec, input bit fips);
        logic [127:0] exp;
        int kidx;
        dir_dec = dec; start = 1'b1; tick; start = 1'b0; dir_dec = 1'b0;
        for (int r = 0; r <= 10; r++) begin
            if (r > 0) begin
                if (r % 4 == 0) begin
                    tick;
                    check(rkey_valid && round_idx == 4'(r-1), "R11 hold without advance",
                          128'(round_idx), 128'(r-1));
                end
                advance = 1'b1; tick; advance = 1'b0;
            end
            kidx = dec ? 10 - r : r;
            exp  = fips ? fips_rk[kidx] : model_rk(key, kidx);
            check(rkey_valid && round_idx == 4'(r), dec ? "R7 round index" : "R3 round index",
                  128'(round_idx), 128'(r));
            check(rkey == exp, dec ? "R7 backward key" : (r == 0 ? "R2 first key" : "R3 forward key"),
                  rkey, exp);
            if (!dec && r == 10)
                check(dec_ready, "R6 ready after enc pass", 128'(dec_ready), 1);
        end
        advance = 1'b1; tick; advance = 1'b0;
        check(!rkey_valid, "R4 pass ends", 128'(rkey_valid), 0);
        advance = 1'b1; tick; advance = 1'b0;
        check(!rkey_valid && round_idx == 0, "R11 advance while idle", 128'(rkey_valid), 0);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [127:0] k0;
        logic [127:0] kz;
        logic [7:0] inv, v;
        for (int x = 0; x < 256; x++) begin
            inv = 8'h00;
            for (int y = 1; y < 256; y++) if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            v = inv;
            sb[x] = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                      ^ {v[3:0], v[7:4]} ^ 8'h63;
        end
        fips_rk[0]  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
        fips_rk[1]  = 128'ha0fafe1788542cb123a339392a6c7605;
        fips_rk[2]  = 128'hf2c295f27a96b9435935807a7359f67f;
        fips_rk[3]  = 128'h3d80477d4716fe3e1e237e446d7a883b;
        fips_rk[4]  = 128'hef44a541a8525b7fb671253bdb0bad00;
        fips_rk[5]  = 128'hd4d1c6f87c839d87caf2b8bc11f915bc;
        fips_rk[6]  = 128'h6d88a37a110b3efddbf98641ca0093fd;
        fips_rk[7]  = 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f;
        fips_rk[8]  = 128'head27321b58dbad2312bf5607f8d292f;
        fips_rk[9]  = 128'hac7766f319fadc2128d12941575c006e;
        fips_rk[10] = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
        k0 = fips_rk[0];
        kz = 128'h0;

        rst = 1'b1; key_load = 0; dir_dec = 0; start = 0; advance = 0; dkgen = 0;
        key_in = '0;
        repeat (3) tick;
        rst = 1'b0;
        tick;
        check(!rkey_valid && !dec_ready && !dec_err && !gen_busy && round_idx == 0,
              "R1 reset state", {rkey_valid, dec_ready, dec_err, gen_busy, round_idx}, 0);

        load_key(k0);
        dir_dec = 1'b1; start = 1'b1; tick; start = 1'b0; dir_dec = 1'b0;
        check(dec_err && !rkey_valid, "R8 refused decrypt", {dec_err, rkey_valid}, 2);
        tick;
        check(dec_err && !rkey_valid, "R8 error stays, no key", {dec_err, rkey_valid}, 2);

        run_gen();
        run_pass(k0, 1'b1, 1'b1);
        check(!dec_err, "R8 error cleared by accepted start", 128'(dec_err), 0);
        run_pass(k0, 1'b0, 1'b1);

        // R10: commands in mid-pass are ignored
        start = 1'b1; tick; start = 1'b0;
        advance = 1'b1; tick; tick; advance = 1'b0;
        key_in = kz; key_load = 1'b1; start = 1'b1; dkgen = 1'b1; dir_dec = 1'b1;
        tick;
        key_load = 1'b0; start = 1'b0; dkgen = 1'b0; dir_dec = 1'b0;
        check(rkey_valid && round_idx == 2 && rkey == fips_rk[2], "R10 pass unaffected",
              rkey, fips_rk[2]);
        check(dec_ready, "R10 ready not cleared by ignored load", 128'(dec_ready), 1);
        advance = 1'b1; repeat (9) tick; advance = 1'b0;
        check(!rkey_valid, "R4 pass ends after burst", 128'(rkey_valid), 0);
        start = 1'b1; tick; start = 1'b0;
        check(rkey == k0, "R10 user key kept", rkey, k0);
        advance = 1'b1; repeat (11) tick; advance = 1'b0;

        // R9: load beats start in the same cycle
        key_in = kz; key_load = 1'b1; start = 1'b1; tick; key_load = 1'b0; start = 1'b0;
        check(!rkey_valid && !dec_ready, "R9 load wins, ready cleared",
              {rkey_valid, dec_ready}, 0);
        dir_dec = 1'b1; start = 1'b1; tick; start = 1'b0; dir_dec = 1'b0;
        check(dec_err && !rkey_valid, "R8 refused after new key", 128'(dec_err), 1);
        key_in = kz; key_load = 1'b1; tick; key_load = 1'b0;
        check(!dec_err, "R9 load clears error", 128'(dec_err), 0);

        // R9: dkgen beats start
        dkgen = 1'b1; start = 1'b1; tick; dkgen = 1'b0; start = 1'b0;
        check(gen_busy && !rkey_valid, "R9 dkgen wins over start", {gen_busy, rkey_valid}, 2);
        while (gen_busy) tick;
        run_pass(kz, 1'b1, 1'b0);

        // sweep of keys through both routes to the cached tail
        for (int s = 0; s < 8; s++) begin
            logic [127:0] k;
            k = {32'(s) * 32'h9e3779b9, ~(32'(s) * 32'h7f4a7c15),
                 32'(s) * 32'h85ebca6b ^ 32'h0f0f00ff, 32'(s + 1) * 32'hc2b2ae35};
            load_key(k);
            check(!dec_ready, "R9 load clears ready", 128'(dec_ready), 0);
            if (s % 2 == 0) begin
                dkgen = 1'b1; tick; dkgen = 1'b0;
                key_in = ~k; key_load = 1'b1; tick; key_load = 1'b0;
                while (gen_busy) tick;
                check(dec_ready, "R10 load during gen ignored", 128'(dec_ready), 1);
            end else begin
                run_pass(k, 1'b0, 1'b0);
            end
            run_pass(k, 1'b1, 1'b0);
        end

        finish_up();
    end
endmodule